// File: doc/BRIEF.md
# Parallel EEPROM Page Programmer

This block sits on the host side of a byte-wide parallel nonvolatile memory. It writes a page of up to 32 bytes and then waits for the memory's internal program cycle to finish. The host first fills a small internal buffer through a simple write port. It then issues a start request that carries the page number and the byte count less one. The controller drives the address, the write data and the three active-low strobes. Each interval (address/data setup, write-enable low time, hold, bus turnaround and read access) is a number of clock cycles set by a parameter.

Byte loads follow one another at a fixed, short pitch. This keeps every load well inside the memory's byte-load window, so programming does not start before the page is complete. After the last load the controller releases the data bus. It then reads the last written location again and again until the value read back equals the byte that was written. It then pulses `done`. If that match does not appear within a timeout set by a parameter, it pulses `error` instead. `busy` stays high from the accepted start until one of the two pulses.

The host must not write the buffer while `busy` is high. `PAGE_BYTES` must be a power of two.

Top module: `eeprom_page_writer`

## Requirements
- R1: While `rst_n` is low, and after it is released, the outputs `mem_ce_n`, `mem_oe_n` and `mem_we_n` are 1. `mem_dq_oe`, `busy`, `done` and `error` are 0.
- R2: A start with page P and count field N writes N+1 bytes in ascending index order. Byte i goes to address {P, i}: the page occupies address bits 12..5 and the index occupies bits 4..0. Its data is buffer entry i.
- R3: Each write-enable low pulse lasts exactly `T_WE_LOW` cycles. Throughout the pulse, chip-enable is low, output-enable is high and the data bus is driven.
- R4: Address and data are stable for at least `T_SETUP` cycles before write-enable falls. They stay stable through the pulse and for `T_HOLD` cycles after write-enable rises.
- R5: Within one page, the time from a write-enable rising edge to the next falling edge is exactly `T_HOLD + T_SETUP` cycles. This is below `LOAD_WINDOW`.
- R6: Polling reads start only after every byte of the page has been loaded. Each read has chip-enable and output-enable low and the data bus released (`mem_dq_oe` = 0), and it addresses the last written location.
- R7: When a polling read returns a byte equal to the last written byte, `done` pulses for exactly one cycle. `busy` goes low in the same cycle, and `error` stays 0.
- R8: If no polling read matches within `TIMEOUT_CYC` cycles of the start of polling, `error` pulses for one cycle, `busy` goes low, and `done` stays 0.
- R9: A start request while `busy` is high is ignored. The running page keeps its page, count and data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| buf_we | input | 1 | Write strobe for the page buffer |
| buf_waddr | input | 5 | Page buffer entry to write |
| buf_wdata | input | 8 | Byte stored in the page buffer |
| start | input | 1 | Start request, taken only while idle |
| page_addr | input | 8 | Page number, becomes address bits 12..5 |
| byte_count_m1 | input | 5 | Number of bytes to write, minus one |
| busy | output | 1 | High from accepted start until done or error |
| done | output | 1 | One-cycle pulse on successful completion |
| error | output | 1 | One-cycle pulse on polling timeout |
| mem_addr | output | 13 | Memory address |
| mem_dq_out | output | 8 | Write data toward memory |
| mem_dq_oe | output | 1 | Drive enable for the data bus |
| mem_dq_in | input | 8 | Data read back from memory |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |

## Verification
Full 32-byte pages, single-byte pages and partial pages are written. Their last bytes have the top bit set in some runs and clear in others. This shows whether the index walk stops at the right count and whether completion depends on the whole read-back byte rather than on a fixed delay. The memory model returns a wrong value for a chosen number of cycles after each load: no cycles, a few hundred, or practically forever. This separates an immediate match, a match after repeated polls and a timeout. A second start issued in the middle of a page checks that the running transfer is not disturbed.

// File: rtl/epw_pkg.sv
// Package: shared types for the parallel EEPROM page programmer.
// Assumes nothing beyond standard SystemVerilog enums.
package epw_pkg;
    // Controller sequencing states
    typedef enum logic [2:0] {
        S_IDLE,     // waiting for start
        S_SETUP,    // address/data presented, write-enable still high
        S_WE_LOW,   // write-enable pulse
        S_HOLD,     // write-enable high, address/data held
        S_TURN,     // bus released before the first poll read
        S_READ,     // poll read in progress
        S_GAP       // strobes high between poll reads
    } epw_state_t;
endpackage

// File: rtl/epw_page_buf.sv
// Module: epw_page_buf
// Small register file holding the bytes of one page. One write port for the
// host, one combinational read port for the sequencer. Assumes the host does
// not write while a transfer is running; contents are not reset.
module epw_page_buf #(
    parameter int DEPTH = 32,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);
    logic [DW-1:0] mem_q [DEPTH];

    // Store one byte per host write
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[wr_addr] <= wr_data;
        end
    end

    // Present the entry selected by the sequencer
    always_comb begin
        rd_data = mem_q[rd_addr];
    end
endmodule

// File: rtl/epw_interval_timer.sv
// Module: epw_interval_timer
// Down counter that measures one strobe interval. Loading value V makes
// 'zero' rise V cycles later, so a state that leaves on 'zero' lasts V+1 cycles.
module epw_interval_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt_q;

    // Load a new interval or count the current one down to zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // Interval elapsed
    always_comb begin
        zero = (cnt_q == '0);
    end
endmodule

// File: rtl/epw_poll_watch.sv
// Module: epw_poll_watch
// Counts cycles while polling is active and flags expiry after LIMIT cycles.
// Cleared whenever 'run' is low; saturates once expired.
module epw_poll_watch #(
    parameter int LIMIT = 1000,
    localparam int CW   = $clog2(LIMIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    logic [CW-1:0] cnt_q;

    // Count polling cycles, hold once the limit is reached
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q <= '0;
        end else if (!expired) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Limit reached
    always_comb begin
        expired = (cnt_q == CW'(LIMIT));
    end

    // R8: the counter never runs past its limit
    a_r8_watch_bound: assert property (@(posedge clk) disable iff (!rst_n)
        expired |=> (!run || expired));
endmodule

// File: rtl/eeprom_page_writer.sv
// Module: eeprom_page_writer
// Writes one page (1..PAGE_BYTES bytes) from an internal buffer into a
// byte-wide parallel EEPROM. Each byte load is framed by setup, write-enable
// low and hold intervals counted in clock cycles. Loads follow one another at
// a fixed pitch that stays inside the memory's byte-load window. Afterwards
// the bus is released and the last location is read back until it returns
// the written byte, or until the timeout expires.
// Assumes: PAGE_BYTES is a power of two, all interval parameters are >= 1,
// and the buffer is not written while busy.
module eeprom_page_writer
    import epw_pkg::*;
#(
    parameter int PAGE_BYTES  = 32,
    parameter int DATA_W      = 8,
    parameter int PAGE_W      = 8,
    parameter int T_SETUP     = 2,
    parameter int T_WE_LOW    = 30,
    parameter int T_HOLD      = 3,
    parameter int T_TURN      = 3,
    parameter int T_ACCESS    = 40,
    parameter int TIMEOUT_CYC = 2_500_000,
    parameter int LOAD_WINDOW = 25_000,
    localparam int IDX_W      = $clog2(PAGE_BYTES),
    localparam int ADDR_W     = PAGE_W + IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              buf_we,
    input  logic [IDX_W-1:0]  buf_waddr,
    input  logic [DATA_W-1:0] buf_wdata,
    input  logic              start,
    input  logic [PAGE_W-1:0] page_addr,
    input  logic [IDX_W-1:0]  byte_count_m1,
    output logic              busy,
    output logic              done,
    output logic              error,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    output logic              mem_we_n
);
    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    localparam int TMAX = max_of(max_of(max_of(T_SETUP, T_WE_LOW), max_of(T_HOLD, T_TURN)), T_ACCESS);
    localparam int TW   = $clog2(TMAX + 1);
    localparam int GW   = $clog2(LOAD_WINDOW + 1);

    epw_state_t        state_q, state_d;
    logic [PAGE_W-1:0] page_q;
    logic [IDX_W-1:0]  idx_q;
    logic [IDX_W-1:0]  last_q;
    logic [DATA_W-1:0] poll_q;
    logic [DATA_W-1:0] buf_rd;
    logic              tmr_load;
    logic [TW-1:0]     tmr_val;
    logic              tmr_zero;
    logic              tmo_expired;
    logic              poll_run;
    logic              accept;
    logic              idx_step;
    logic              fin_ok;
    logic              fin_err;
    logic              read_hit;

    epw_page_buf #(.DEPTH(PAGE_BYTES), .DW(DATA_W)) u_buf (
        .clk     (clk),
        .wr_en   (buf_we),
        .wr_addr (buf_waddr),
        .wr_data (buf_wdata),
        .rd_addr (idx_q),
        .rd_data (buf_rd)
    );

    epw_interval_timer #(.W(TW)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    epw_poll_watch #(.LIMIT(TIMEOUT_CYC)) u_watch (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (poll_run),
        .expired (tmo_expired)
    );

    // Polling phase drives the timeout watch
    always_comb begin
        poll_run = (state_q == S_TURN) || (state_q == S_READ) || (state_q == S_GAP);
        read_hit = (mem_dq_in == poll_q);
    end

    // Next-state, interval loading and completion decisions
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        accept   = 1'b0;
        idx_step = 1'b0;
        fin_ok   = 1'b0;
        fin_err  = 1'b0;
        unique case (state_q)
            S_IDLE: if (start) begin
                accept   = 1'b1;
                state_d  = S_SETUP;
                tmr_load = 1'b1;
                tmr_val  = TW'(T_SETUP - 1);
            end
            S_SETUP: if (tmr_zero) begin
                state_d  = S_WE_LOW;
                tmr_load = 1'b1;
                tmr_val  = TW'(T_WE_LOW - 1);
            end
            S_WE_LOW: if (tmr_zero) begin
                state_d  = S_HOLD;
                tmr_load = 1'b1;
                tmr_val  = TW'(T_HOLD - 1);
            end
            S_HOLD: if (tmr_zero) begin
                tmr_load = 1'b1;
                if (idx_q == last_q) begin
                    state_d = S_TURN;
                    tmr_val = TW'(T_TURN - 1);
                end else begin
                    idx_step = 1'b1;
                    state_d  = S_SETUP;
                    tmr_val  = TW'(T_SETUP - 1);
                end
            end
            S_TURN: if (tmr_zero) begin
                state_d  = S_READ;
                tmr_load = 1'b1;
                tmr_val  = TW'(T_ACCESS - 1);
            end
            S_READ: if (tmr_zero) begin
                if (read_hit) begin
                    fin_ok  = 1'b1;
                    state_d = S_IDLE;
                end else if (tmo_expired) begin
                    fin_err = 1'b1;
                    state_d = S_IDLE;
                end else begin
                    state_d  = S_GAP;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(T_TURN - 1);
                end
            end
            S_GAP: if (tmo_expired) begin
                fin_err = 1'b1;
                state_d = S_IDLE;
            end else if (tmr_zero) begin
                state_d  = S_READ;
                tmr_load = 1'b1;
                tmr_val  = TW'(T_ACCESS - 1);
            end
            default: state_d = S_IDLE;
        endcase
    end

    // Sequencer registers: state, page context, byte index and result pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            page_q  <= '0;
            idx_q   <= '0;
            last_q  <= '0;
            poll_q  <= '0;
            done    <= 1'b0;
            error   <= 1'b0;
        end else begin
            state_q <= state_d;
            done    <= fin_ok;
            error   <= fin_err;
            if (accept) begin
                page_q <= page_addr;
                last_q <= byte_count_m1;
                idx_q  <= '0;
            end else if (idx_step) begin
                idx_q <= idx_q + 1'b1;
            end
            if (state_q == S_HOLD && idx_q == last_q) begin
                poll_q <= buf_rd;
            end
        end
    end

    // Memory strobes and bus decoded from the registered state
    always_comb begin
        busy       = (state_q != S_IDLE);
        mem_dq_oe  = (state_q == S_SETUP) || (state_q == S_WE_LOW) || (state_q == S_HOLD);
        mem_ce_n   = !(mem_dq_oe || (state_q == S_READ));
        mem_we_n   = (state_q != S_WE_LOW);
        mem_oe_n   = (state_q != S_READ);
        mem_addr   = {page_q, idx_q};
        mem_dq_out = buf_rd;
    end

    // ---------------- assertions ----------------
    logic [TW:0] we_low_len;
    logic [GW-1:0] load_gap;

    // Length of the current write-enable low pulse
    always_ff @(posedge clk) begin
        if (!rst_n || mem_we_n) we_low_len <= '0;
        else                    we_low_len <= we_low_len + 1'b1;
    end

    // Cycles since the last write-enable rise within a page (saturating)
    always_ff @(posedge clk) begin
        if (!rst_n || state_q == S_IDLE || !mem_we_n) load_gap <= '0;
        else if (load_gap != GW'(LOAD_WINDOW))       load_gap <= load_gap + 1'b1;
    end

    // R3: write pulse width
    a_r3_we_width: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (we_low_len == (TW+1)'(T_WE_LOW)));
    // R3: strobe combination during a load
    a_r3_we_strobes: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (!mem_ce_n && mem_oe_n && mem_dq_oe));
    // R4: address and data frozen while write-enable is low
    a_r4_we_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_we_n && !$past(mem_we_n)) |-> ($stable(mem_addr) && $stable(mem_dq_out)));
    // R5: next load begins inside the byte-load window
    a_r5_load_window: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_we_n) |-> (load_gap < GW'(LOAD_WINDOW)));
    // R6: data bus released whenever the memory drives it
    a_r6_bus_released: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> (!mem_dq_oe && mem_we_n));
    // R7: only one outcome, and it ends the busy phase
    a_r7_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        (done || error) |-> (!busy && !(done && error)));
    // R8: error only after the watch expired
    a_r8_error_expired: assert property (@(posedge clk) disable iff (!rst_n)
        error |-> $past(tmo_expired));
    // R9: start while busy leaves the page context untouched
    a_r9_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> ($stable(page_q) && $stable(last_q)));
endmodule

// File: tb/sim_eeprom_page_writer.sv
`timescale 1ns/1ps
module sim_eeprom_page_writer;
    localparam int TS  = 2;
    localparam int TWL = 5;
    localparam int TH  = 3;
    localparam int TT  = 2;
    localparam int TA  = 4;
    localparam int TMO = 3000;
    localparam int LW  = 50;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        buf_we = 1'b0;
    logic [4:0]  buf_waddr = '0;
    logic [7:0]  buf_wdata = '0;
    logic        start = 1'b0;
    logic [7:0]  page_addr = '0;
    logic [4:0]  byte_count_m1 = '0;
    logic        busy, done, error;
    logic [12:0] mem_addr;
    logic [7:0]  mem_dq_out;
    logic        mem_dq_oe;
    logic [7:0]  mem_dq_in;
    logic        mem_ce_n, mem_oe_n, mem_we_n;

    int checks = 0;
    int errors = 0;

    // memory model and monitor state
    int          prog_cfg = 0;
    int          prog_left;
    logic [12:0] last_addr;
    logic [7:0]  last_data;
    logic [12:0] log_addr [64];
    logic [7:0]  log_data [64];
    int nwr, nreads, v3, v4, v5, v6, done_cnt, err_cnt, lowlen, hilen, stab;
    int cyc, rise_cyc, end_cyc;
    logic prev_we, hold_act, clr;
    logic [20:0] ad_prev;
    int exp_n;
    logic [12:0] exp_last;

    always #2 clk = ~clk;

    eeprom_page_writer #(
        .T_SETUP(TS), .T_WE_LOW(TWL), .T_HOLD(TH), .T_TURN(TT),
        .T_ACCESS(TA), .TIMEOUT_CYC(TMO), .LOAD_WINDOW(LW)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .buf_we(buf_we), .buf_waddr(buf_waddr),
        .buf_wdata(buf_wdata), .start(start), .page_addr(page_addr),
        .byte_count_m1(byte_count_m1), .busy(busy), .done(done), .error(error),
        .mem_addr(mem_addr), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
        .mem_dq_in(mem_dq_in), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
        .mem_we_n(mem_we_n)
    );

    // memory model answer: wrong byte while programming or at a foreign address
    assign mem_dq_in = (prog_left == 0 && mem_addr == last_addr) ? last_data : ~last_data;

    // monitor: samples on the falling edge, away from the active edge
    always @(negedge clk) begin
        logic [20:0] ad_now;
        logic chg;
        cyc = cyc + 1;
        if (!rst_n || clr) begin
            nwr = 0; nreads = 0; v3 = 0; v4 = 0; v5 = 0; v6 = 0;
            done_cnt = 0; err_cnt = 0; lowlen = 0; hilen = 0; stab = 0;
            prev_we = 1'b1; hold_act = 1'b0; ad_prev = '0;
            if (!rst_n) begin prog_left = 0; last_addr = '0; last_data = '0; end
        end else begin
            ad_now = {mem_addr, mem_dq_out};
            chg = (ad_now != ad_prev);
            stab = chg ? 1 : stab + 1;
            if (prog_left > 0) prog_left = prog_left - 1;
            if (done) done_cnt = done_cnt + 1;
            if (error) begin err_cnt = err_cnt + 1; end_cyc = cyc; end
            if (!mem_we_n) begin
                if (!mem_oe_n || mem_ce_n || !mem_dq_oe) v3 = v3 + 1;
                if (prev_we) begin
                    if (stab < TS + 1) v4 = v4 + 1;
                    if (nwr > 0 && hilen != TH + TS) v5 = v5 + 1;
                end else if (chg) v4 = v4 + 1;
                lowlen = lowlen + 1;
                hold_act = 1'b0;
            end else begin
                if (!prev_we) begin
                    if (lowlen != TWL) v3 = v3 + 1;
                    if (nwr < 64) begin log_addr[nwr] = mem_addr; log_data[nwr] = mem_dq_out; end
                    nwr = nwr + 1;
                    last_addr = mem_addr; last_data = mem_dq_out;
                    prog_left = prog_cfg;
                    rise_cyc = cyc;
                    hilen = 0;
                    hold_act = 1'b1;
                end
                hilen = hilen + 1;
                if (chg && hold_act && hilen <= TH) v4 = v4 + 1;
                lowlen = 0;
            end
            if (!mem_oe_n) begin
                nreads = nreads + 1;
                if (mem_dq_oe || mem_ce_n || mem_addr != exp_last || nwr < exp_n) v6 = v6 + 1;
            end
            prev_we = mem_we_n;
            ad_prev = ad_now;
        end
    end

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic clear_stats();
        clr = 1'b1; step(); step(); clr = 1'b0;
    endtask

    task automatic fill(input int n, input int bias);
        for (int i = 0; i < n; i++) begin
            buf_we = 1'b1; buf_waddr = 5'(i); buf_wdata = 8'((i * 37 + bias) & 255);
            step();
        end
        buf_we = 1'b0;
    endtask

    task automatic wait_end(input int limit);
        for (int i = 0; i < limit; i++) begin
            if (done_cnt + err_cnt > 0) break;
            step();
        end
        repeat (4) step();
    endtask

    // R1: idle outputs after reset
    task automatic t_reset();
        rst_n = 1'b0; repeat (3) step();
        chk(mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe, "R1 strobes in reset",
            {mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe}, 4'b1110);
        rst_n = 1'b1; clr = 1'b0; repeat (2) step();
        chk(!busy && !done && !error, "R1 status after reset", {busy, done, error}, 0);
        chk(mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe, "R1 strobes after reset",
            {mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe}, 4'b1110);
    endtask

    // R2..R7: one complete page with a given programming delay
    task automatic t_page(input int page, input int n, input int bias, input int prog);
        int bad = 0;
        fill(n, bias);
        prog_cfg = prog; exp_n = n; exp_last = 13'((page << 5) | (n - 1));
        clear_stats();
        start = 1'b1; page_addr = 8'(page); byte_count_m1 = 5'(n - 1);
        step(); start = 1'b0;
        wait_end(prog + 40 * n + 500);
        chk(nwr == n, "R2 byte count", nwr, n);
        for (int i = 0; i < n && i < 64; i++) begin
            if (log_addr[i] != 13'((page << 5) | i) || log_data[i] != 8'((i * 37 + bias) & 255)) bad++;
        end
        chk(bad == 0, "R2 address/data order", bad, 0);
        chk(v3 == 0, "R3 pulse width and strobes", v3, 0);
        chk(v4 == 0, "R4 setup/hold stability", v4, 0);
        chk(v5 == 0, "R5 load pitch", v5, 0);
        chk(v6 == 0 && nreads > 0, "R6 poll reads", v6, 0);
        chk(done_cnt == 1 && err_cnt == 0, "R7 done pulse", done_cnt * 10 + err_cnt, 10);
        chk(!busy, "R7 busy released", busy, 0);
    endtask

    // R8: memory never finishes, expect the timeout error
    task automatic t_timeout();
        fill(3, 9);
        prog_cfg = 1_000_000; exp_n = 3; exp_last = 13'((8'h5A << 5) | 2);
        clear_stats();
        start = 1'b1; page_addr = 8'h5A; byte_count_m1 = 5'd2;
        step(); start = 1'b0;
        wait_end(TMO + 1000);
        chk(err_cnt == 1 && done_cnt == 0, "R8 error pulse", err_cnt * 10 + done_cnt, 10);
        chk(end_cyc - rise_cyc >= TMO && end_cyc - rise_cyc < TMO + 20, "R8 timeout length",
            end_cyc - rise_cyc, TMO);
        chk(!busy, "R8 busy released", busy, 0);
        chk(v6 == 0 && nreads > 1, "R8 repeated polls", nreads, 2);
    endtask

    // R9: second start in the middle of a page is ignored
    task automatic t_busy_ignore();
        int bad = 0;
        fill(4, 3);
        prog_cfg = 50; exp_n = 4; exp_last = 13'((8'h3C << 5) | 3);
        clear_stats();
        start = 1'b1; page_addr = 8'h3C; byte_count_m1 = 5'd3;
        step(); start = 1'b0;
        repeat (6) step();
        start = 1'b1; page_addr = 8'h99; byte_count_m1 = 5'd9;
        step(); start = 1'b0;
        wait_end(2000);
        chk(nwr == 4, "R9 count kept", nwr, 4);
        for (int i = 0; i < nwr && i < 64; i++) if (log_addr[i][12:5] != 8'h3C) bad++;
        chk(bad == 0, "R9 page kept", bad, 0);
        chk(done_cnt == 1, "R9 single completion", done_cnt, 1);
        repeat (40) step();
        chk(nwr == 4 && !busy, "R9 no restart", nwr, 4);
    endtask

    // watchdog
    initial begin
        repeat (190000) @(posedge clk);
        errors = errors + 1;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        clr = 1'b0;
        t_reset();
        t_page(8'hA5, 32, 8'h11, 300);
        t_page(8'h00, 1, 8'h80, 0);
        t_page(8'hFF, 7, 8'h40, 120);
        t_timeout();
        t_busy_ignore();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule